// File: doc/BRIEF.md
# Parallel Window Reduction Datapath (Absolute-Difference / Convolution)

This block reduces one complete two-dimensional window of 16-bit unsigned grayscale pixels to a single number on every clock cycle. An upstream window former presents all WIN_H×WIN_W pixels at once, flattened into one bus. The block combines each pixel with a matching coefficient taken from a locally held coefficient set of the same shape, then sums all the point-wise results.

In absolute-difference mode, each pixel is paired with the coefficient at the same position. The magnitude of their difference is summed, which gives a block-matching cost. In convolution mode, each pixel is multiplied by the coefficient at the mirrored position. The products are summed, which gives a filter output. The mode travels with each window, so back-to-back windows may use different modes.

The point-wise stage is registered, and it feeds a binary adder tree with a register after every level. The block therefore accepts a window on every cycle without stalling. A fixed number of cycles later, it delivers the matching result with its own valid and mode flags. Coefficients are loaded one at a time through a small write port while no windows are being presented.

Top module: `wdp_core`

## Requirements
- R1: While the reset input is low, and until the first window has passed through, out_valid is 0 and out_sum is 0. Every coefficient reads as 0 after reset, so an absolute-difference window then yields the plain sum of its pixels and a convolution window yields 0.
- R2: With in_mode = 0, the result is the sum over i of |w[i] − k[i]|. Here w[i] is the pixel in bits [16i+15:16i] of in_win, with i = row·WIN_W + col, and k[i] is coefficient i.
- R3: With in_mode = 1, the result is the sum over i of w[i]·k[N−1−i], where N = WIN_H·WIN_W. The coefficient order is mirrored.
- R4: A window accepted with in_valid = 1 on a clock edge produces out_valid = 1 exactly LAT = 1 + ceil(log2(N)) edges later, and out_valid is 0 in every other cycle.
- R5: A new window may be accepted on every cycle, with either mode. Each result appears in acceptance order, with out_mode equal to the in_mode sampled with its window.
- R6: out_sum is 32 + ceil(log2(N)) bits wide and never wraps. All-ones pixels against all-ones coefficients in convolution mode give N·65535², and an absolute-difference result never exceeds N·65535.
- R7: A write with cfg_we = 1 stores cfg_data into coefficient cfg_addr, and windows accepted on later edges use the new value. A write whose address is N or above changes no coefficient.
- R8: On a cycle with out_valid = 0, out_sum keeps the value it had on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | ceil(log2(N)) | Coefficient index, row-major |
| cfg_data | input | PIX_W | Coefficient value |
| in_valid | input | 1 | Window present on in_win |
| in_mode | input | 1 | 0 = absolute difference, 1 = mirrored convolution |
| in_win | input | N·PIX_W | Flattened window, element i at bits [PIX_W·i +: PIX_W] |
| out_valid | output | 1 | Result present on out_sum |
| out_mode | output | 1 | Mode that produced the current result |
| out_sum | output | 2·PIX_W + ceil(log2(N)) | Reduced result |

## Verification
Single-element impulse windows are applied at every position in convolution mode. A datapath that indexed the coefficients forward instead of mirrored would return the wrong coefficient for every off-centre position. All-ones operands in both modes are aimed at carries lost in a narrow adder level. Random gaps in in_valid and interleaved modes are used against a valid chain or a mode pipeline that is one stage off, which would misalign results or mislabel them. Writes to addresses past the last coefficient are followed by a zero window, which exposes any aliasing of those writes onto real coefficients.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

  typedef enum logic {
    MODE_ABSDIFF = 1'b0,
    MODE_CONV    = 1'b1
  } wdp_mode_e;

endpackage

// File: rtl/wdp_kernel_regs.sv
module wdp_kernel_regs #(
  parameter int ELEMS = 9,
  parameter int PIX_W = 16,
  parameter int AW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [PIX_W-1:0]         wr_data,
  output logic [ELEMS*PIX_W-1:0]   kern_flat
);

  for (genvar i = 0; i < ELEMS; i++) begin : g_coef
    logic             hit;
    logic [PIX_W-1:0] coef_q;

    assign hit = wr_en && (int'(wr_addr) == i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        coef_q <= '0;
      end else if (hit) begin
        coef_q <= wr_data;
      end
    end

    assign kern_flat[i*PIX_W +: PIX_W] = coef_q;
  end

endmodule

// File: rtl/wdp_pointwise.sv
module wdp_pointwise
  import wdp_pkg::*;
#(
  parameter int ELEMS = 9,
  parameter int PIX_W = 16,
  localparam int RES_W = 2*PIX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_mode,
  input  logic [ELEMS*PIX_W-1:0]   win_flat,
  input  logic [ELEMS*PIX_W-1:0]   kern_flat,
  output logic                     pw_valid,
  output logic                     pw_mode,
  output logic [ELEMS*RES_W-1:0]   pw_flat
);

  logic [ELEMS*RES_W-1:0] res_d;
  logic [ELEMS*RES_W-1:0] res_q;
  logic                   vld_q;
  logic                   mode_q;

  for (genvar i = 0; i < ELEMS; i++) begin : g_elem
    logic [PIX_W-1:0] pix;
    logic [PIX_W-1:0] k_same;
    logic [PIX_W-1:0] k_mirror;
    logic [PIX_W-1:0] mag;
    logic [RES_W-1:0] prod;

    assign pix      = win_flat[i*PIX_W +: PIX_W];
    assign k_same   = kern_flat[i*PIX_W +: PIX_W];
    assign k_mirror = kern_flat[(ELEMS-1-i)*PIX_W +: PIX_W];
    assign mag      = (pix >= k_same) ? (pix - k_same) : (k_same - pix);
    assign prod     = RES_W'(pix) * RES_W'(k_mirror);

    assign res_d[i*RES_W +: RES_W] =
      (in_mode == MODE_CONV) ? prod : RES_W'(mag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      vld_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q  <= res_d;
        mode_q <= in_mode;
      end
    end
  end

  assign pw_valid = vld_q;
  assign pw_mode  = mode_q;
  assign pw_flat  = res_q;

endmodule

// File: rtl/wdp_addtree.sv
module wdp_addtree #(
  parameter int ELEMS = 9,
  parameter int IN_W  = 32,
  parameter int LVLS  = 4,
  parameter int OUT_W = 36
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_mode,
  input  logic [ELEMS*IN_W-1:0]   in_flat,
  output logic                    out_valid,
  output logic                    out_mode,
  output logic [OUT_W-1:0]        out_sum
);

  localparam int LEAVES = 1 << LVLS;

  logic [OUT_W-1:0] leaf   [LEAVES];
  logic [OUT_W-1:0] view   [LVLS+1][LEAVES];
  logic [OUT_W-1:0] node_d [LVLS+1][LEAVES];
  logic [OUT_W-1:0] node_q [LVLS+1][LEAVES];
  logic [LVLS:1]    v_q;
  logic [LVLS:1]    m_q;
  logic [LVLS:0]    v_chain;
  logic [LVLS:0]    m_chain;

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < ELEMS) begin : g_real
      assign leaf[j] = OUT_W'(in_flat[j*IN_W +: IN_W]);
    end else begin : g_pad
      assign leaf[j] = '0;
    end
  end

  assign v_chain = {v_q, in_valid};
  assign m_chain = {m_q, in_mode};

  always_comb begin
    view[0] = leaf;
    for (int l = 1; l <= LVLS; l++) begin
      view[l] = node_q[l];
    end
    for (int l = 0; l <= LVLS; l++) begin
      for (int j = 0; j < LEAVES; j++) begin
        node_d[l][j] = '0;
      end
    end
    for (int l = 1; l <= LVLS; l++) begin
      for (int j = 0; j < (LEAVES >> l); j++) begin
        node_d[l][j] = view[l-1][2*j] + view[l-1][2*j+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l <= LVLS; l++) begin
        for (int j = 0; j < LEAVES; j++) begin
          node_q[l][j] <= '0;
        end
      end
      v_q <= '0;
      m_q <= '0;
    end else begin
      for (int l = 1; l <= LVLS; l++) begin
        v_q[l] <= v_chain[l-1];
        if (v_chain[l-1]) begin
          m_q[l] <= m_chain[l-1];
          for (int j = 0; j < LEAVES; j++) begin
            node_q[l][j] <= node_d[l][j];
          end
        end
      end
    end
  end

  assign out_sum   = node_q[LVLS][0];
  assign out_valid = v_q[LVLS];
  assign out_mode  = m_q[LVLS];

endmodule

// File: rtl/wdp_core.sv
module wdp_core #(
  parameter int WIN_H = 3,
  parameter int WIN_W = 3,
  parameter int PIX_W = 16,
  localparam int ELEMS = WIN_H * WIN_W,
  localparam int LVLS  = $clog2(ELEMS),
  localparam int AW    = LVLS,
  localparam int RES_W = 2 * PIX_W,
  localparam int OUT_W = RES_W + LVLS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [AW-1:0]           cfg_addr,
  input  logic [PIX_W-1:0]        cfg_data,
  input  logic                    in_valid,
  input  logic                    in_mode,
  input  logic [ELEMS*PIX_W-1:0]  in_win,
  output logic                    out_valid,
  output logic                    out_mode,
  output logic [OUT_W-1:0]        out_sum
);

  logic [1:0]               rst_pipe;
  logic                     rst_sync_n;
  logic [ELEMS*PIX_W-1:0]   kern_flat;
  logic                     pw_valid;
  logic                     pw_mode;
  logic [ELEMS*RES_W-1:0]   pw_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  wdp_kernel_regs #(
    .ELEMS (ELEMS),
    .PIX_W (PIX_W),
    .AW    (AW)
  ) u_coef (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (cfg_we),
    .wr_addr   (cfg_addr),
    .wr_data   (cfg_data),
    .kern_flat (kern_flat)
  );

  wdp_pointwise #(
    .ELEMS (ELEMS),
    .PIX_W (PIX_W)
  ) u_pw (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .win_flat  (in_win),
    .kern_flat (kern_flat),
    .pw_valid  (pw_valid),
    .pw_mode   (pw_mode),
    .pw_flat   (pw_flat)
  );

  wdp_addtree #(
    .ELEMS (ELEMS),
    .IN_W  (RES_W),
    .LVLS  (LVLS),
    .OUT_W (OUT_W)
  ) u_tree (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (pw_valid),
    .in_mode   (pw_mode),
    .in_flat   (pw_flat),
    .out_valid (out_valid),
    .out_mode  (out_mode),
    .out_sum   (out_sum)
  );

endmodule

// File: rtl/wdp_core_chk.sv
module wdp_core_chk #(
  parameter int WIN_H = 3,
  parameter int WIN_W = 3,
  parameter int PIX_W = 16,
  localparam int ELEMS = WIN_H * WIN_W,
  localparam int LVLS  = $clog2(ELEMS),
  localparam int LAT   = 1 + LVLS,
  localparam int OUT_W = 2 * PIX_W + LVLS
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             in_valid,
  input logic             in_mode,
  input logic             out_valid,
  input logic             out_mode,
  input logic [OUT_W-1:0] out_sum
);

  localparam longint ABS_MAX = longint'(ELEMS) * ((longint'(1) << PIX_W) - 1);

  logic [LAT-1:0] v_sh;
  logic [LAT-1:0] m_sh;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      v_sh <= '0;
      m_sh <= '0;
    end else begin
      v_sh <= {v_sh[LAT-2:0], in_valid};
      m_sh <= {m_sh[LAT-2:0], in_mode};
    end
  end

  p_fixed_latency_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid == v_sh[LAT-1]);

  p_mode_follows_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (out_mode == m_sh[LAT-1]));

  p_absdiff_bound_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_mode) |-> (longint'(out_sum) <= ABS_MAX));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !out_valid |-> $stable(out_sum));

endmodule

bind wdp_core wdp_core_chk #(
  .WIN_H (WIN_H),
  .WIN_W (WIN_W),
  .PIX_W (PIX_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_mode    (in_mode),
  .out_valid  (out_valid),
  .out_mode   (out_mode),
  .out_sum    (out_sum)
);

// File: tb/wdp_core_tb.sv
`timescale 1ns/1ps
module wdp_core_tb_top;

  localparam int WIN_H = 3;
  localparam int WIN_W = 3;
  localparam int PIX_W = 16;
  localparam int N     = WIN_H * WIN_W;
  localparam int LVLS  = $clog2(N);
  localparam int AW    = LVLS;
  localparam int LAT   = 1 + LVLS;
  localparam int OUT_W = 2 * PIX_W + LVLS;
  localparam int WB    = N * PIX_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [AW-1:0]    cfg_addr;
  logic [PIX_W-1:0] cfg_data;
  logic             in_valid;
  logic             in_mode;
  logic [WB-1:0]    in_win;
  logic             out_valid;
  logic             out_mode;
  logic [OUT_W-1:0] out_sum;

  always #4 clk = ~clk;

  wdp_core #(.WIN_H(WIN_H), .WIN_W(WIN_W), .PIX_W(PIX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_mode(in_mode),
    .in_win(in_win), .out_valid(out_valid), .out_mode(out_mode),
    .out_sum(out_sum)
  );

  int     n_checks = 0;
  int     n_fail   = 0;
  int     pe       = 0;
  longint kref [N];
  int     due_q  [$];
  bit     mode_q [$];
  longint sum_q  [$];
  longint last_sum = 0;
  string  req = "R1";

  always @(posedge clk) begin
    pe <= pe + 1;
    if (pe > 60000) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected below 60000", pe);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint ref_sum(input bit m, input logic [WB-1:0] w);
    longint s = 0;
    for (int i = 0; i < N; i++) begin
      longint p = longint'(w[i*PIX_W +: PIX_W]);
      if (m) s += p * kref[N-1-i];
      else   s += (p >= kref[i]) ? (p - kref[i]) : (kref[i] - p);
    end
    return s;
  endfunction

  function automatic logic [WB-1:0] rand_win();
    logic [WB-1:0] w;
    for (int i = 0; i < N; i++) w[i*PIX_W +: PIX_W] = PIX_W'($urandom);
    return w;
  endfunction

  function automatic logic [WB-1:0] fill_win(input int v);
    logic [WB-1:0] w;
    for (int i = 0; i < N; i++) w[i*PIX_W +: PIX_W] = PIX_W'(v);
    return w;
  endfunction

  task automatic observe();
    if (due_q.size() > 0 && due_q[0] == pe) begin
      chk({req, " out_valid"}, longint'(out_valid), 1);
      chk({req, " out_mode"},  longint'(out_mode), longint'(mode_q[0]));
      chk({req, " out_sum"},   longint'(out_sum),  sum_q[0]);
      last_sum = sum_q[0];
      void'(due_q.pop_front());
      void'(mode_q.pop_front());
      void'(sum_q.pop_front());
    end else begin
      chk("R4 idle out_valid", longint'(out_valid), 0);
      chk("R8 idle out_sum hold", longint'(out_sum), last_sum);
    end
  endtask

  task automatic step(input bit v, input bit m, input logic [WB-1:0] w);
    @(negedge clk);
    observe();
    cfg_we   = 1'b0;
    in_valid = v;
    in_mode  = m;
    in_win   = w;
    if (v) begin
      due_q.push_back(pe + LAT);
      mode_q.push_back(m);
      sum_q.push_back(ref_sum(m, w));
    end
  endtask

  task automatic kwrite(input int a, input int d);
    @(negedge clk);
    observe();
    in_valid = 1'b0;
    cfg_we   = 1'b1;
    cfg_addr = AW'(a);
    cfg_data = PIX_W'(d);
    if (a < N) kref[a] = longint'(d & 16'hFFFF);
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) step(1'b0, 1'b0, '0);
  endtask

  initial begin
    logic [WB-1:0] w;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    in_valid = 1'b0; in_mode = 1'b0; in_win = '0;
    for (int i = 0; i < N; i++) kref[i] = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", longint'(out_valid), 0);
    chk("R1 reset out_sum", longint'(out_sum), 0);
    rst_n = 1'b1;
    req = "R1";
    idle(4);
    for (int i = 0; i < N; i++) w[i*PIX_W +: PIX_W] = PIX_W'(i*100 + 7);
    step(1'b0 | 1'b1, 1'b0, w);
    step(1'b1, 1'b1, w);
    idle(LAT + 1);

    // R7: coefficient load, out-of-range writes ignored
    req = "R7";
    for (int i = 0; i < N; i++) kwrite(i, (i+1)*1000 + i*37);
    for (int a = N; a < (1 << AW); a++) kwrite(a, 16'hFFFF);
    step(1'b1, 1'b0, '0);
    w = '0; w[PIX_W-1:0] = 16'd1;
    step(1'b1, 1'b1, w);
    idle(LAT + 1);

    // R2: absolute difference, back-to-back random
    req = "R2";
    for (int i = 0; i < N; i++) kwrite(i, int'($urandom & 16'hFFFF));
    for (int c = 0; c < 16; c++) step(1'b1, 1'b0, rand_win());
    idle(LAT + 1);

    // R3: mirrored convolution, impulses at each position then random
    req = "R3";
    for (int i = 0; i < N; i++) begin
      w = '0; w[i*PIX_W +: PIX_W] = 16'd1;
      step(1'b1, 1'b1, w);
    end
    for (int c = 0; c < 16; c++) step(1'b1, 1'b1, rand_win());
    idle(LAT + 1);

    // R5: interleaved modes every cycle
    req = "R5";
    for (int c = 0; c < 24; c++) step(1'b1, c[0], rand_win());
    idle(LAT + 1);

    // R4: random valid gaps and modes
    req = "R4";
    for (int c = 0; c < 48; c++) step(bit'($urandom & 1), bit'($urandom & 1), rand_win());
    idle(LAT + 1);

    // R6: extreme operands
    req = "R6";
    for (int i = 0; i < N; i++) kwrite(i, 16'hFFFF);
    step(1'b1, 1'b1, fill_win(16'hFFFF));
    step(1'b1, 1'b0, '0);
    idle(LAT + 1);
    for (int i = 0; i < N; i++) kwrite(i, 0);
    step(1'b1, 1'b0, fill_win(16'hFFFF));
    step(1'b1, 1'b1, fill_win(16'hFFFF));
    idle(LAT + 2);

    chk("R4 all results delivered", longint'(due_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule